// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This controller turns single-byte read and write requests from a synchronous valid/ready bus into pin sequences for an external asynchronous static RAM. The RAM is 512K x 8 and has two chip selects: one is active low and one is active high. Output enable and write enable are both active low. Every timing window is a whole number of system clock cycles. Each window is rounded up from a nanosecond parameter at the clock period. Only one access is in flight at a time. The controller holds `req_ready` low from the cycle a request is accepted until the cycle it acknowledges the request.

The data bus is brought out as three signals: a drive value, a drive enable and a sampled input. The pad tristate sits outside the block and uses the drive enable. A write keeps the address and both chip selects stable for a setup window. It then holds write enable low for the pulse window and keeps driving data for one cycle after write enable rises. A read holds both chip selects and output enable asserted for one read-cycle window and captures the byte on the last cycle of that window.

A sleep input sends the controller into a retention state, where the memory is held deselected. When sleep is released, a wake-up counter of one read-cycle time must expire before new requests are accepted.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, mem_cs1_n=1, mem_cs2=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, rsp_valid=0 and req_ready=1.
- R2: A write holds mem_we_n low for exactly WP_CYC consecutive cycles (4 at defaults). Before mem_we_n falls, the chips are selected for exactly SU_CYC cycles (1 at defaults) with mem_we_n high. Address, data and selects stay constant while mem_we_n is low.
- R3: mem_dq_oe is 1 in every cycle with mem_we_n low and in the single cycle after mem_we_n rises, and is 0 otherwise. It is never 1 while mem_oe_n is 0.
- R4: mem_oe_n and mem_we_n are never both 0. mem_oe_n is 0 only while mem_cs1_n=0 and mem_cs2=1.
- R5: A read holds mem_oe_n low with the chips selected for exactly RC_CYC cycles (6 at defaults). The byte on mem_dq_i in the last of those cycles appears on rsp_rdata with a one-cycle rsp_valid, RC_CYC+1 cycles after the accepting edge.
- R6: A write stores req_wdata at req_addr and gives a one-cycle rsp_valid SU_CYC+WP_CYC+2 cycles after the accepting edge.
- R7: A request is accepted only when req_ready is 1. req_ready is 0 from the accepting edge until the acknowledge cycle, and requests presented meanwhile cause no memory access.
- R8: With sleep_req high in an idle cycle, the controller enters retention. req_ready drops at once, mem_cs1_n=1 and mem_cs2=0 are held, and a simultaneous request is not accepted.
- R9: After the first edge that samples sleep_req low, req_ready stays 0 for exactly RC_CYC cycles and then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | DW | Captured read byte |
| sleep_req | input | 1 | Enter/hold retention while high |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_o |
| mem_dq_i | input | DW | Data sampled from the memory pins |

## Verification
The sleep request and an access request can both arrive in the same idle cycle. The bench raises both on one clock edge. It then judges that retention took priority: req_ready fell in that same cycle, the chip selects stayed inactive, the model memory saw no write, and only the wake-up delay elapsed before req_ready returned. A second collision is the acknowledge cycle against a request that was held up by back-pressure. The bench keeps a write request asserted through a busy window and withdraws it before the acknowledge edge. It then checks that exactly one write reached the memory and that the second address still reads its old value.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW      = 19,
  parameter int DW      = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 40,
  parameter int T_CW_NS = 45,
  parameter int T_RC_NS = 55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          sleep_req,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int WP_CYC = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int CW_CYC = (T_CW_NS + CLK_NS - 1) / CLK_NS;
  localparam int SU_CYC = (CW_CYC > WP_CYC) ? CW_CYC - WP_CYC : 1;
  localparam int RC_CYC = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int MAXC   = (WP_CYC > RC_CYC) ? ((WP_CYC > SU_CYC) ? WP_CYC : SU_CYC)
                                            : ((RC_CYC > SU_CYC) ? RC_CYC : SU_CYC);
  localparam int CNW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WSU, S_WPL, S_WHD, S_RD, S_SLP, S_WAKE} st_t;

  st_t           st;
  logic [CNW-1:0] cnt;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic           ack_q, sel, done;

  assign sel       = (st == S_WSU) || (st == S_WPL) || (st == S_WHD) || (st == S_RD);
  assign done      = (cnt == '0);
  assign req_ready = (st == S_IDLE) && !sleep_req;
  assign mem_cs1_n = !sel;
  assign mem_cs2   = sel;
  assign mem_oe_n  = (st != S_RD);
  assign mem_we_n  = (st != S_WPL);
  assign mem_dq_oe = (st == S_WPL) || (st == S_WHD);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_valid = ack_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (sleep_req) begin
            st <= S_SLP;
          end else if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            if (req_write) begin
              st  <= S_WSU;
              cnt <= CNW'(SU_CYC - 1);
            end else begin
              st  <= S_RD;
              cnt <= CNW'(RC_CYC - 1);
            end
          end
        end
        S_WSU: begin
          if (done) begin
            st  <= S_WPL;
            cnt <= CNW'(WP_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_WPL: begin
          if (done) st <= S_WHD;
          else      cnt <= cnt - 1'b1;
        end
        S_WHD: begin
          st    <= S_IDLE;
          ack_q <= 1'b1;
        end
        S_RD: begin
          if (done) begin
            rdata_q <= mem_dq_i;
            ack_q   <= 1'b1;
            st      <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        S_SLP: begin
          if (!sleep_req) begin
            st  <= S_WAKE;
            cnt <= CNW'(RC_CYC - 1);
          end
        end
        S_WAKE: begin
          if (done) st <= S_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r4_oe_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs1_n && mem_cs2));

  a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r3_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  a_r3_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

  a_r2_pulse_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o) && !mem_cs1_n));

  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r8_sleep_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep_req) && sleep_req && $past(req_ready == 1'b0) && mem_cs1_n) |-> !mem_cs2);

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int WP = 4;
  localparam int SU = 1;
  localparam int RC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, sleep_req = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, we_run = 0, oe_run = 0, cs_pre = 0;
  int su_seen = 0, last_wp = 0, last_rd = 0;
  int viol2 = 0, viol3 = 0, viol4 = 0;
  logic        prev_we = 1'b1;
  logic [18:0] wp_addr = '0;
  logic [7:0]  mem [256];
  logic        act;

  always #4 clk = ~clk;

  sram_async_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sleep_req(sleep_req),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  assign act      = !mem_cs1_n && mem_cs2;
  assign mem_dq_i = (act && !mem_oe_n && mem_we_n) ? mem[mem_addr[7:0]] : 8'hEE;

  always @(negedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 8'h00;
    end else begin
      if (!act) cs_pre = 0;
      else if (mem_we_n && prev_we && we_run == 0) cs_pre++;
      if (!mem_we_n) begin
        if (prev_we) begin su_seen = cs_pre; wp_addr = mem_addr; we_run = 0; end
        we_run++;
        if (!act || mem_addr != wp_addr) viol2++;
        if (!mem_dq_oe) viol3++;
      end
      if (!mem_oe_n && !mem_we_n) viol4++;
      if (!mem_oe_n && !act) viol4++;
      if (mem_dq_oe && !mem_oe_n) viol3++;
      if (mem_dq_oe && mem_we_n && prev_we) viol3++;
      if (mem_we_n && !prev_we) begin
        last_wp = we_run;
        if (mem_dq_oe && act) mem[mem_addr[7:0]] = mem_dq_o;
        wr_cnt++;
        we_run = 0;
        cs_pre = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin last_rd = oe_run; rd_cnt++; oe_run = 0; end
      prev_we = mem_we_n;
    end
  end

  task automatic chk(input string rq, input int act_v, input int exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act_v, exp_v);
    end
  endtask

  task automatic t_reset();
    chk("R1 cs1_n", int'(mem_cs1_n), 1);
    chk("R1 cs2", int'(mem_cs2), 0);
    chk("R1 oe_n", int'(mem_oe_n), 1);
    chk("R1 we_n", int'(mem_we_n), 1);
    chk("R1 dq_oe", int'(mem_dq_oe), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 req_ready", int'(req_ready), 1);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int w0 = wr_cnt;
    int lat = 1;
    @(negedge clk);
    chk("R7 ready before write", int'(req_ready), 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 busy after accept", int'(req_ready), 0);
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    chk("R6 write ack latency", lat, SU + WP + 2);
    chk("R2 pulse width", last_wp, WP);
    chk("R2 setup cycles", su_seen, SU);
    chk("R6 one write committed", wr_cnt - w0, 1);
    @(negedge clk);
    chk("R6 ack one cycle", int'(rsp_valid), 0);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] e);
    int r0 = rd_cnt;
    int lat = 1;
    @(negedge clk);
    chk("R7 ready before read", int'(req_ready), 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    chk("R5 read ack latency", lat, RC + 1);
    chk("R5 read data", int'(rsp_rdata), int'(e));
    @(negedge clk);
    chk("R5 ack one cycle", int'(rsp_valid), 0);
    chk("R5 oe window", last_rd, RC);
    chk("R5 one read", rd_cnt - r0, 1);
  endtask

  task automatic t_basic();
    do_write(19'h0_0011, 8'hA5);
    do_write(19'h7_FF22, 8'h3C);
    do_read(19'h0_0011, 8'hA5);
    do_read(19'h7_FF22, 8'h3C);
  endtask

  task automatic t_busy();
    int w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h0_0040; req_wdata = 8'h77;
    @(negedge clk);
    req_addr = 19'h0_0041; req_wdata = 8'h99;
    repeat (4) begin
      @(negedge clk);
      chk("R7 ready low while busy", int'(req_ready), 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R7 ack after busy", int'(rsp_valid), 1);
    chk("R7 single access", wr_cnt - w0, 1);
    @(negedge clk);
    do_read(19'h0_0041, 8'h00);
    do_read(19'h0_0040, 8'h77);
  endtask

  task automatic t_back_to_back();
    do_read(19'h0_0011, 8'hA5);
    do_write(19'h0_0012, 8'h5A);
    do_read(19'h0_0012, 8'h5A);
  endtask

  task automatic t_sleep();
    int w0 = wr_cnt;
    int r0 = rd_cnt;
    int n = 0;
    @(negedge clk);
    sleep_req = 1'b1; req_valid = 1'b1; req_write = 1'b1;
    req_addr = 19'h0_0050; req_wdata = 8'hC3;
    #1;
    chk("R8 ready drops with sleep", int'(req_ready), 0);
    repeat (5) begin
      @(negedge clk);
      chk("R8 cs1_n held", int'(mem_cs1_n), 1);
      chk("R8 cs2 held", int'(mem_cs2), 0);
    end
    req_valid = 1'b0;
    chk("R8 no access", (wr_cnt - w0) + (rd_cnt - r0), 0);
    sleep_req = 1'b0;
    @(negedge clk);
    while (!req_ready && n < 50) begin n++; @(negedge clk); end
    chk("R9 wake delay", n, RC);
    do_read(19'h0_0050, 8'h00);
  endtask

  task automatic t_protocol();
    chk("R2 stable pulse", viol2, 0);
    chk("R3 drive window", viol3, 0);
    chk("R4 oe/we exclusion", viol4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy();
    t_back_to_back();
    t_sleep();
    t_protocol();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule